// File: doc/BRIEF.md
# Operand-Tracking Computation Unit Controller

This controller takes charge of one execution unit, which may be a combinational function or a multi-cycle engine, for the whole life of an operation. It starts when the operation is issued and ends when the result has been written back. While it holds an operation it keeps `busy_o` high, so scheduling logic elsewhere always knows the unit is occupied. No result is dropped, because the execution unit's result is not acknowledged until the write grant has arrived.

An issue pulse captures the operation record. The record holds the opcode, the invert-A flag, the immediate value and its valid flag, the zero-A flag and a two-bit read mask. For each source operand that is really needed, the controller raises a read request and waits for a one-cycle grant that carries the operand. The operands are passed to the execution unit with a valid/ready handshake. The result comes back over a second valid/ready pair and is offered to the register file through a write request and grant pair. Read grants may come in any order, in the same cycle, or after any delay.

Top module: `compunit_ctrl`

## Requirements
- R1: After reset, `busy_o`, both bits of `rd_req_o`, `wr_req_o` and `eu_valid_o` are low.
- R2: An issue is accepted only in a cycle where `busy_o` is low. `busy_o` goes high in the next cycle and stays high until the cycle after the write grant is taken, when it falls. `busy_o` never rises without an accepted issue.
- R3: The opcode, invert-A flag, immediate value, immediate-valid flag, zero-A flag and read mask are captured in the issue cycle. Changing these inputs afterwards has no effect on the operation.
- R4: For a needed port, `rd_req_o[i]` rises in the cycle after the issue and stays high until its grant is sampled. It falls in the following cycle and does not rise again before the next issue. Bit 0 is operand A and bit 1 is operand B.
- R5: A grant given in the first cycle of a request is accepted. During the grant cycle, the `src_*_i` value appears combinationally on the matching `eu_a_o` or `eu_b_o` output.
- R6: With the immediate-valid flag set, no request is raised on bit 1, and operand B is the captured immediate.
- R7: With the zero-A flag set, no request is raised on bit 0, and operand A is zero.
- R8: A set bit `i` of the read mask, taken at issue, suppresses request `i`. The operand is then zero, or the immediate for bit 1 when the immediate-valid flag is set.
- R9: Grants may arrive in either order or together. `eu_valid_o` is raised only once all needed operands are present, and it is accepted exactly once per operation.
- R10: `wr_req_o` is high when the execution unit's result is valid and the operands have been handed over. `wr_data_o` carries the result while `wr_gnt_i` is high. `res_ready_o` is high only in the cycle the write grant is taken.
- R11: An `issue_i` pulse while `busy_o` is high is ignored. It changes neither the running operation nor the busy state after that operation ends.
- R12: A zero-latency execution unit is supported. With prompt handshakes, an operation completes within 50 cycles of the issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Issue pulse for a new operation |
| op_code_i | input | OPW | Opcode |
| op_inv_a_i | input | 1 | Invert operand A |
| op_imm_i | input | W | Immediate value |
| op_imm_ok_i | input | 1 | Immediate replaces operand B |
| op_zero_a_i | input | 1 | Operand A forced to zero |
| rd_mask_i | input | 2 | Per-port read suppression |
| busy_o | output | 1 | Operation in progress |
| rd_req_o | output | 2 | Read requests (bit 0 = A, bit 1 = B) |
| rd_gnt_i | input | 2 | One-cycle read grants |
| src_a_i | input | W | Operand A data, valid with grant |
| src_b_i | input | W | Operand B data, valid with grant |
| eu_valid_o | output | 1 | Operands valid to execution unit |
| eu_ready_i | input | 1 | Execution unit accepts operands |
| eu_op_o | output | OPW | Captured opcode |
| eu_inv_a_o | output | 1 | Captured invert-A flag |
| eu_a_o | output | W | Operand A to execution unit |
| eu_b_o | output | W | Operand B to execution unit |
| res_valid_i | input | 1 | Result valid from execution unit |
| res_ready_o | output | 1 | Result accepted |
| res_data_i | input | W | Result from execution unit |
| wr_req_o | output | 1 | Write request |
| wr_gnt_i | input | 1 | One-cycle write grant |
| wr_data_o | output | W | Result to be written |

## Verification
Operations are run with read-grant delays that bring in A first, B first, and both in the same cycle. A zero delay shows that a grant in the first request cycle is taken, and longer delays show that the request is held. Some runs use the immediate, zero-A and mask options, alone and together. These show that the suppressed port stays quiet while its operand value still reaches the result. Add, subtract and invert-A opcodes are run against both a multi-cycle and a zero-latency execution model. Scrambling the fields after issue, and issuing again mid-operation, both leave the result unchanged, which shows that the fields are captured only at issue.

// File: rtl/compunit_ctrl.sv
module compunit_ctrl #(
  parameter int W   = 16,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue_i,
  input  logic [OPW-1:0] op_code_i,
  input  logic           op_inv_a_i,
  input  logic [W-1:0]   op_imm_i,
  input  logic           op_imm_ok_i,
  input  logic           op_zero_a_i,
  input  logic [1:0]     rd_mask_i,
  output logic           busy_o,
  output logic [1:0]     rd_req_o,
  input  logic [1:0]     rd_gnt_i,
  input  logic [W-1:0]   src_a_i,
  input  logic [W-1:0]   src_b_i,
  output logic           eu_valid_o,
  input  logic           eu_ready_i,
  output logic [OPW-1:0] eu_op_o,
  output logic           eu_inv_a_o,
  output logic [W-1:0]   eu_a_o,
  output logic [W-1:0]   eu_b_o,
  input  logic           res_valid_i,
  output logic           res_ready_o,
  input  logic [W-1:0]   res_data_i,
  output logic           wr_req_o,
  input  logic           wr_gnt_i,
  output logic [W-1:0]   wr_data_o
);
  localparam int NRD = 2;

  logic           busy_q, sent_q;
  logic [NRD-1:0] pend_q;
  logic [OPW-1:0] op_q;
  logic           inv_q;
  logic [W-1:0]   a_q, b_q;

  logic           accept, fire, handed, finish;
  logic [NRD-1:0] need, take;

  assign accept = issue_i & ~busy_q;
  assign need   = {~op_imm_ok_i & ~rd_mask_i[1], ~op_zero_a_i & ~rd_mask_i[0]};
  assign take   = pend_q & rd_gnt_i;

  assign eu_valid_o = busy_q & ~sent_q & ((pend_q & ~rd_gnt_i) == '0);
  assign fire       = eu_valid_o & eu_ready_i;
  assign handed     = sent_q | fire;

  assign eu_a_o     = take[0] ? src_a_i : a_q;
  assign eu_b_o     = take[1] ? src_b_i : b_q;
  assign eu_op_o    = op_q;
  assign eu_inv_a_o = inv_q;

  assign wr_req_o    = busy_q & handed & res_valid_i;
  assign res_ready_o = wr_req_o & wr_gnt_i;
  assign finish      = res_ready_o;
  assign wr_data_o   = res_data_i;

  assign busy_o   = busy_q;
  assign rd_req_o = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
      pend_q <= '0;
      op_q   <= '0;
      inv_q  <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      sent_q <= 1'b0;
      pend_q <= need;
      op_q   <= op_code_i;
      inv_q  <= op_inv_a_i;
      a_q    <= '0;
      b_q    <= op_imm_ok_i ? op_imm_i : '0;
    end else begin
      if (take[0]) a_q <= src_a_i;
      if (take[1]) b_q <= src_b_i;
      pend_q <= pend_q & ~rd_gnt_i;
      if (fire) sent_q <= 1'b1;
      if (finish) begin
        busy_q <= 1'b0;
        sent_q <= 1'b0;
      end
    end
  end

  p_busy_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(issue_i));
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !(wr_req_o && wr_gnt_i) |=> busy_o);
  p_busy_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o && wr_gnt_i |=> !busy_o);
  p_eu_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eu_valid_o && eu_ready_i |=> !eu_valid_o);
  p_wr_in_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> busy_o);
  p_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && busy_o |=> $stable(eu_op_o) && $stable(eu_inv_a_o));

  for (genvar i = 0; i < NRD; i++) begin : g_rd_chk
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o[i] && !rd_gnt_i[i] |=> rd_req_o[i]);
    p_req_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o[i] && rd_gnt_i[i] |=> !rd_req_o[i]);
    p_req_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_req_o[i]) |-> $past(issue_i && !busy_o));
  end
endmodule

// File: tb/tb_compunit_ctrl.sv
module tb_compunit_ctrl;
  localparam int W = 16;
  localparam int OPW = 4;
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0;
  logic issue_i = 0, op_inv_a_i = 0, op_imm_ok_i = 0, op_zero_a_i = 0;
  logic [OPW-1:0] op_code_i = '0;
  logic [W-1:0] op_imm_i = '0, src_a_i = '0, src_b_i = '0, res_data_i;
  logic [1:0] rd_mask_i = '0;
  logic g0 = 0, g1 = 0, wr_gnt_i = 0;
  logic busy_o, eu_valid_o, eu_ready_i, eu_inv_a_o, res_valid_i, res_ready_o, wr_req_o;
  logic [1:0] rd_req_o;
  logic [OPW-1:0] eu_op_o;
  logic [W-1:0] eu_a_o, eu_b_o, wr_data_o;

  int nchk = 0, nfail = 0;
  int eu_lat = 2;
  bit finished = 0;

  always #(TCLK/2) clk = ~clk;

  compunit_ctrl #(.W(W), .OPW(OPW)) dut (
    .clk, .rst_n, .issue_i, .op_code_i, .op_inv_a_i, .op_imm_i, .op_imm_ok_i,
    .op_zero_a_i, .rd_mask_i, .busy_o, .rd_req_o, .rd_gnt_i({g1, g0}),
    .src_a_i, .src_b_i, .eu_valid_o, .eu_ready_i, .eu_op_o, .eu_inv_a_o,
    .eu_a_o, .eu_b_o, .res_valid_i, .res_ready_o, .res_data_i,
    .wr_req_o, .wr_gnt_i, .wr_data_o);

  // execution-unit model: op 0 = add, op 1 = subtract, inv flips A first
  function automatic logic [W-1:0] calc(logic [OPW-1:0] op, logic inv, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] x;
    x = inv ? ~a : a;
    return (op == 1) ? x - b : x + b;
  endfunction

  logic eu_busy_q = 0, rv_q = 0, hold_q = 0;
  int eu_cnt = 0;
  logic [W-1:0] res_q = '0;
  logic eu_fire;
  assign eu_ready_i = (eu_lat == 0) ? 1'b1 : !eu_busy_q;
  assign eu_fire = eu_valid_o & eu_ready_i;
  assign res_valid_i = (eu_lat == 0) ? (eu_fire | hold_q) : rv_q;
  assign res_data_i = (eu_lat == 0) ? calc(eu_op_o, eu_inv_a_o, eu_a_o, eu_b_o) : res_q;

  always @(posedge clk) begin
    if (eu_lat == 0) begin
      if (eu_fire && !res_ready_o) hold_q <= 1;
      else if (hold_q && res_ready_o) hold_q <= 0;
    end else begin
      if (eu_fire) begin
        eu_busy_q <= 1; eu_cnt <= eu_lat;
        res_q <= calc(eu_op_o, eu_inv_a_o, eu_a_o, eu_b_o);
      end else if (eu_busy_q && !rv_q) begin
        eu_cnt <= eu_cnt - 1;
        if (eu_cnt <= 1) rv_q <= 1;
      end else if (rv_q && res_ready_o) begin
        rv_q <= 0; eu_busy_q <= 0;
      end
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic port_a(bit needed, int d, logic [W-1:0] v);
    if (needed) begin
      while (!rd_req_o[0]) @(negedge clk);
      repeat (d) @(negedge clk);
      g0 = 1; src_a_i = v;
      #1 chk(eu_a_o == v, "R5", eu_a_o, v);
      @(negedge clk);
      g0 = 0; src_a_i = '0;
      chk(rd_req_o[0] == 0, "R4", rd_req_o[0], 0);
    end else begin
      do begin
        chk(rd_req_o[0] == 0, "R7/R8 port A quiet", rd_req_o[0], 0);
        @(negedge clk);
      end while (busy_o);
    end
  endtask

  task automatic port_b(bit needed, int d, logic [W-1:0] v);
    if (needed) begin
      while (!rd_req_o[1]) @(negedge clk);
      repeat (d) @(negedge clk);
      g1 = 1; src_b_i = v;
      #1 chk(eu_b_o == v, "R5", eu_b_o, v);
      @(negedge clk);
      g1 = 0; src_b_i = '0;
      chk(rd_req_o[1] == 0, "R4", rd_req_o[1], 0);
    end else begin
      do begin
        chk(rd_req_o[1] == 0, "R6/R8 port B quiet", rd_req_o[1], 0);
        @(negedge clk);
      end while (busy_o);
    end
  endtask

  task automatic run_op(string tag, logic [OPW-1:0] op, logic inv, logic [W-1:0] a, logic [W-1:0] b,
                        logic [W-1:0] imm, logic imm_ok, logic zero_a, logic [1:0] mask,
                        int da, int db, int dw, int lat, bit poke, logic [W-1:0] exp);
    bit need_a, need_b;
    int cyc;
    need_a = !zero_a && !mask[0];
    need_b = !imm_ok && !mask[1];
    eu_lat = lat;
    @(negedge clk);
    chk(busy_o == 0, {"R2 idle at issue ", tag}, busy_o, 0);
    op_code_i = op; op_inv_a_i = inv; op_imm_i = imm; op_imm_ok_i = imm_ok;
    op_zero_a_i = zero_a; rd_mask_i = mask; issue_i = 1;
    @(negedge clk);
    issue_i = 0;
    op_code_i = ~op; op_inv_a_i = ~inv; op_imm_i = ~imm; op_imm_ok_i = ~imm_ok;
    op_zero_a_i = ~zero_a; rd_mask_i = ~mask;
    chk(busy_o == 1, {"R2 busy after issue ", tag}, busy_o, 1);
    chk(rd_req_o == {need_b, need_a}, {"R4 requests ", tag}, rd_req_o, {need_b, need_a});
    cyc = 1;
    fork
      port_a(need_a, da, a);
      port_b(need_b, db, b);
      begin
        while (!wr_req_o) begin @(negedge clk); cyc++; end
        chk(res_ready_o == 0, {"R10 no ready before grant ", tag}, res_ready_o, 0);
        repeat (dw) begin @(negedge clk); cyc++; end
        wr_gnt_i = 1;
        #1 chk(wr_data_o == exp, {"R10 result ", tag}, wr_data_o, exp);
        chk(res_ready_o == 1, {"R10 ready with grant ", tag}, res_ready_o, 1);
        @(negedge clk);
        wr_gnt_i = 0;
        chk(busy_o == 0, {"R2 busy drop ", tag}, busy_o, 0);
        chk(cyc <= 50, {"R12 bounded ", tag}, cyc, 50);
      end
      if (poke) begin
        @(negedge clk);
        issue_i = 1; op_code_i = 1; op_zero_a_i = 1; op_imm_ok_i = 1; op_imm_i = 16'h5a5a;
        @(negedge clk);
        issue_i = 0;
      end
    join
    op_code_i = '0; op_inv_a_i = 0; op_imm_i = '0; op_imm_ok_i = 0; op_zero_a_i = 0; rd_mask_i = '0;
    repeat (2) @(negedge clk);
    chk(busy_o == 0 && rd_req_o == 0, {"R11 stays idle ", tag}, busy_o, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(rd_req_o == 0, "R1 rd_req", rd_req_o, 0);
    chk(wr_req_o == 0 && eu_valid_o == 0, "R1 wr/eu", {wr_req_o, eu_valid_o}, 0);
  endtask

  task automatic t_a_first;    run_op("R9 A first",   0, 0, 13, 2, 0, 0, 0, 2'b00, 0, 2, 0, 2, 0, 15);    endtask
  task automatic t_b_first;    run_op("R9 B first",   1, 0, 30, 4, 0, 0, 0, 2'b00, 2, 0, 2, 3, 0, 26);    endtask
  task automatic t_together;   run_op("R9 together",  0, 0, 21, 9, 0, 0, 0, 2'b00, 1, 1, 1, 1, 0, 30);   endtask
  task automatic t_imm;        run_op("R6 immediate", 0, 0, 5, 2, 8, 1, 0, 2'b00, 2, 0, 2, 2, 0, 13);    endtask
  task automatic t_zero_imm;   run_op("R7 zero+imm",  0, 0, 5, 2, 8, 1, 1, 2'b00, 0, 2, 0, 1, 0, 8);     endtask
  task automatic t_zero;       run_op("R7 zero",      0, 0, 5, 2, 0, 0, 1, 2'b00, 2, 0, 1, 2, 0, 2);     endtask
  task automatic t_inv;        run_op("R3 invert",    0, 1, 5, 2, 0, 0, 0, 2'b00, 1, 2, 0, 2, 0, 16'hfffc); endtask
  task automatic t_mask;       run_op("R8 mask B",    0, 0, 7, 9, 0, 0, 0, 2'b10, 0, 0, 1, 2, 0, 7);     endtask
  task automatic t_mask_a;     run_op("R8 mask A",    1, 0, 7, 9, 0, 0, 0, 2'b01, 0, 3, 0, 1, 0, 16'hfff7); endtask
  task automatic t_comb;       run_op("R12 comb",     1, 0, 5, 2, 0, 0, 0, 2'b00, 0, 1, 2, 0, 0, 3);     endtask
  task automatic t_comb_now;   run_op("R12 comb now", 0, 0, 40, 2, 0, 0, 0, 2'b00, 0, 0, 0, 0, 0, 42);   endtask
  task automatic t_poke;       run_op("R11 poke",     0, 0, 100, 1, 0, 0, 0, 2'b00, 3, 3, 4, 3, 1, 101); endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset; t_a_first; t_b_first; t_together; t_imm; t_zero_imm; t_zero;
        t_inv; t_mask; t_mask_a; t_comb; t_comb_now; t_poke;
        finished = 1;
      end
      begin
        repeat (20000) @(negedge clk);
        if (!finished) begin
          nchk++; nfail++;
          $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule